// File: doc/BRIEF.md
# SPI FIFO Status and Event Controller

This block sits between a processor register bus and an SPI shift engine. It holds two 8-entry word FIFOs: the transmit FIFO is filled from the bus and drained by the engine, and the receive FIFO is filled by the engine and drained from the bus. It reports the FIFO levels as status bits and keeps nine sticky event flags. Each flag can be masked, and each is cleared by writing 1 to it. The block drives one interrupt line from the unmasked flags. It also raises request lines for a DMA engine unless a configuration bit selects programmed I/O.

The FIFO flush commands run in a small state machine with three states. IDLE waits for a write to the control register that has a flush bit set; this is the *start* transition to FLUSH. In FLUSH the selected FIFOs are emptied, and the *advance* transition leads to SETTLE. SETTLE clears the command bits that read back as busy, and the *finish* transition returns to IDLE. The device-ready status bit is high only in IDLE. A control write made while a flush is running has no effect.

Register map (3-bit word address): 0 data (a write pushes TX, a read pops RX), 1 status (read only), 2 events (write 1 to clear), 3 mask, 4 flush control, 5 configuration. Reading an unused address returns 0.

Top module: `spi_fec_top`

## Requirements
- R1: The TX FIFO holds 8 words and the engine receives them in the order they were written to address 0. Status bit1 (TX full) is 1 at 8 entries, and status bit5 (TX empty) is 1 at 0 entries.
- R2: A bus write to a full TX FIFO sets event bit1 (TX overflow) and leaves the FIFO contents unchanged. An engine pop from an empty TX FIFO sets event bit2 (TX underflow).
- R3: The bus reads words from the RX FIFO at address 0 in the order the engine pushed them. Status bit0 (RX empty) is 1 when the FIFO holds nothing, and status bit4 (RX full) is 1 at 8 entries.
- R4: An engine push to a full RX FIFO sets event bit4 (RX overflow) and the word is dropped. A bus read from an empty RX FIFO returns 0 and sets event bit5 (RX underflow).
- R5: Event bit0 (TX request) is set while the TX FIFO has at least TX_THR free entries (default 4). Event bit3 (RX request) is set while the RX FIFO holds at least RX_THR words (default 4).
- R6: Engine pulses set the following events: mode mismatch sets bit6, slave done sets bit7, master done sets bit8. Every event bit stays set until 1 is written to that bit at address 2.
- R7: If an event source fires in the same cycle as a write-1-clear of that bit, the bit stays set.
- R8: The mask register (address 3, 9 bits) resets to all ones. A 1 in the mask blocks the matching event. `irq` is the OR of (event AND NOT mask) over all nine bits, and status bit3 shows the same value.
- R9: A write to address 4 with bit0 (RX flush) or bit1 (TX flush) set empties the selected FIFO on the next clock edge. The written bits read back as 1 for two cycles and then return to 0. During those two cycles status bit2 (ready) is 0. A FIFO that was not selected keeps its contents.
- R10: When configuration bit0 (address 5, DMA off) is 0, `dma_tx_req` follows the TX request condition and `dma_rx_req` follows the RX request condition. When it is 1, both request lines are 0.
- R11: After reset both FIFOs are empty, ready is 1, the mask is 0x1FF, `irq` is 0 and the DMA-off bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX at address 0) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| eng_tx_pop | input | 1 | Engine takes the TX head word |
| eng_tx_data | output | DATA_W | TX head word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| eng_mode_mismatch | input | 1 | Mode mismatch event pulse |
| eng_slave_done | input | 1 | Slave done event pulse |
| eng_master_done | input | 1 | Master done event pulse |
| dma_tx_req | output | 1 | TX DMA request |
| dma_rx_req | output | 1 | RX DMA request |
| irq | output | 1 | Masked interrupt |

## Verification
The FIFOs are tried in several ways: a full fill and drain, a write past full, a pop from empty, and short bursts. Together these separate correct ordering from pointer-wrap errors and from dropped or duplicated words. The flush commands are issued one FIFO at a time while the other FIFO holds data, which shows that a flush touches only the FIFO it selects and that its busy readback lasts exactly two cycles. Two event cases are separated: a pulse alone, and a pulse that arrives in the same cycle as a clear. Masked and unmasked master-done events then show that the interrupt depends on the mask as well as on the flag.

// File: rtl/spi_fec_pkg.sv
package spi_fec_pkg;
    localparam int EV_N = 9;
    localparam int EV_TX_REQ = 0;
    localparam int EV_TX_OVF = 1;
    localparam int EV_TX_UNF = 2;
    localparam int EV_RX_REQ = 3;
    localparam int EV_RX_OVF = 4;
    localparam int EV_RX_UNF = 5;
    localparam int EV_MODE   = 6;
    localparam int EV_SLV    = 7;
    localparam int EV_MST    = 8;

    typedef enum logic [2:0] {
        A_DATA = 3'd0,
        A_STAT = 3'd1,
        A_EVT  = 3'd2,
        A_MASK = 3'd3,
        A_CTRL = 3'd4,
        A_CFG  = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        FL_IDLE   = 2'd0,
        FL_FLUSH  = 2'd1,
        FL_SETTLE = 2'd2
    } flush_state_e;
endpackage

// File: rtl/spi_fec_fifo.sv
module spi_fec_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clear;
    assign do_pop  = pop && !empty && !clear;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R1
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clear) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/spi_fec_events.sv
module spi_fec_events #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] mask,
    output logic [N-1:0] ev,
    output logic         irq
);
    logic [N-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_bits : '0;
    assign irq     = |(ev & ~mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev <= '0;
        else        ev <= (ev & ~clr_eff) | set;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> ev[i]);
        // R6
        w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_bits[i] && !set[i]) |=> !ev[i]);
    end
endmodule

// File: rtl/spi_fec_flush.sv
module spi_fec_flush
    import spi_fec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [1:0] cmd,
    output logic [1:0] busy_bits,
    output logic       clr_rx,
    output logic       clr_tx,
    output logic       ready
);
    flush_state_e state, nxt;
    logic         start;

    assign start = (state == FL_IDLE) && cmd_we && (|cmd);

    always_comb begin
        nxt = state;
        unique case (state)
            FL_IDLE:   if (start) nxt = FL_FLUSH;
            FL_FLUSH:  nxt = FL_SETTLE;
            FL_SETTLE: nxt = FL_IDLE;
            default:   nxt = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= FL_IDLE;
            busy_bits <= '0;
        end else begin
            state <= nxt;
            if (start)                   busy_bits <= cmd;
            else if (state == FL_SETTLE) busy_bits <= '0;
        end
    end

    always_comb begin
        ready  = (state == FL_IDLE);
        clr_rx = (state == FL_FLUSH) && busy_bits[0];
        clr_tx = (state == FL_FLUSH) && busy_bits[1];
    end

    // R9
    flush_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!ready && busy_bits == $past(cmd)));

    // R9
    flush_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FL_SETTLE) |=> (ready && busy_bits == 2'b00));
endmodule

// File: rtl/spi_fec_top.sv
module spi_fec_top
    import spi_fec_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 24,
    parameter int TX_THR = 4,
    parameter int RX_THR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_mode_mismatch,
    input  logic              eng_slave_done,
    input  logic              eng_master_done,
    output logic              dma_tx_req,
    output logic              dma_rx_req,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0]     tx_cnt, rx_cnt, tx_free;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              tx_push, rx_pop, clr_rx, clr_tx, ready;
    logic [1:0]        busy_bits;
    logic [EV_N-1:0]   ev, ev_set, mask_q;
    logic              dma_off_q, tx_req_c, rx_req_c;

    assign tx_push  = bus_wr && (bus_addr == A_DATA);
    assign rx_pop   = bus_rd && (bus_addr == A_DATA);
    assign tx_free  = CW'(DEPTH) - tx_cnt;
    assign tx_req_c = tx_free >= CW'(TX_THR);
    assign rx_req_c = rx_cnt >= CW'(RX_THR);

    spi_fec_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .clear(clr_tx),
        .push(tx_push), .wdata(bus_wdata[DATA_W-1:0]),
        .pop(eng_tx_pop), .rdata(eng_tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    spi_fec_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clear(clr_rx),
        .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(rx_pop), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    always_comb begin
        ev_set            = '0;
        ev_set[EV_TX_REQ] = tx_req_c;
        ev_set[EV_TX_OVF] = tx_push && tx_full;
        ev_set[EV_TX_UNF] = eng_tx_pop && tx_empty;
        ev_set[EV_RX_REQ] = rx_req_c;
        ev_set[EV_RX_OVF] = eng_rx_push && rx_full;
        ev_set[EV_RX_UNF] = rx_pop && rx_empty;
        ev_set[EV_MODE]   = eng_mode_mismatch;
        ev_set[EV_SLV]    = eng_slave_done;
        ev_set[EV_MST]    = eng_master_done;
    end

    spi_fec_events #(.N(EV_N)) u_evt (
        .clk(clk), .rst_n(rst_n), .set(ev_set),
        .clr_we(bus_wr && (bus_addr == A_EVT)),
        .clr_bits(bus_wdata[EV_N-1:0]),
        .mask(mask_q), .ev(ev), .irq(irq));

    spi_fec_flush u_flush (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(bus_wr && (bus_addr == A_CTRL)),
        .cmd(bus_wdata[1:0]), .busy_bits(busy_bits),
        .clr_rx(clr_rx), .clr_tx(clr_tx), .ready(ready));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '1;
            dma_off_q <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_MASK) mask_q    <= bus_wdata[EV_N-1:0];
            if (bus_addr == A_CFG)  dma_off_q <= bus_wdata[0];
        end
    end

    assign dma_tx_req = !dma_off_q && tx_req_c;
    assign dma_rx_req = !dma_off_q && rx_req_c;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA: bus_rdata[DATA_W-1:0] = rx_head;
            A_STAT: bus_rdata[5:0] = {tx_empty, rx_full, irq, ready, tx_full, rx_empty};
            A_EVT:  bus_rdata[EV_N-1:0] = ev;
            A_MASK: bus_rdata[EV_N-1:0] = mask_q;
            A_CTRL: bus_rdata[1:0] = busy_bits;
            A_CFG:  bus_rdata[0] = dma_off_q;
            default: bus_rdata = '0;
        endcase
    end

    // R4
    rx_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |=> ev[EV_RX_UNF]);

    // R2
    tx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full && !clr_tx) |=> (ev[EV_TX_OVF] && tx_full));
endmodule

// File: tb/spi_fec_top_tb.sv
`timescale 1ns/1ps
module spi_fec_top_tb;
    localparam int W = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 0, bus_rd = 0;
    logic [2:0]    bus_addr = 0;
    logic [31:0]   bus_wdata = 0;
    logic [31:0]   bus_rdata;
    logic          eng_tx_pop = 0, eng_rx_push = 0;
    logic [W-1:0]  eng_tx_data, eng_rx_data = 0;
    logic          eng_mode_mismatch = 0, eng_slave_done = 0, eng_master_done = 0;
    logic          dma_tx_req, dma_rx_req, irq;

    int n_tests = 0, n_fail = 0;
    logic [W-1:0] tx_exp[$];
    logic [W-1:0] rx_exp[$];
    logic [31:0]  rd;

    always #10 clk = ~clk;

    spi_fec_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_mode_mismatch(eng_mode_mismatch), .eng_slave_done(eng_slave_done),
        .eng_master_done(eng_master_done), .dma_tx_req(dma_tx_req),
        .dma_rx_req(dma_rx_req), .irq(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic rdn, input logic [2:0] a,
                          input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        bus_wr = wr; bus_rd = rdn; bus_addr = a; bus_wdata = d;
        #1 q = bus_rdata;
        @(posedge clk);
        #1 bus_wr = 0; bus_rd = 0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        logic [31:0] q;
        bus_op(1'b1, 1'b0, a, d, q);
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] q);
        bus_op(1'b0, 1'b1, a, 32'h0, q);
    endtask

    // driver: writes TX and records the expected word
    task automatic tx_send(input logic [W-1:0] d, input bit expect_accept);
        if (expect_accept) tx_exp.push_back(d);
        wr_reg(3'd0, {8'h0, d});
    endtask

    // monitor: engine pop, compared against the scoreboard
    task automatic tx_take(input string req);
        logic [W-1:0] got;
        @(negedge clk);
        eng_tx_pop = 1;
        #1 got = eng_tx_data;
        @(posedge clk);
        #1 eng_tx_pop = 0;
        if (tx_exp.size() > 0) chk(req, {8'h0, got}, {8'h0, tx_exp.pop_front()});
    endtask

    task automatic rx_send(input logic [W-1:0] d, input bit expect_accept);
        if (expect_accept) rx_exp.push_back(d);
        @(negedge clk);
        eng_rx_push = 1; eng_rx_data = d;
        @(posedge clk);
        #1 eng_rx_push = 0;
    endtask

    task automatic rx_take(input string req);
        logic [31:0] q;
        rd_reg(3'd0, q);
        if (rx_exp.size() > 0) chk(req, q, {8'h0, rx_exp.pop_front()});
    endtask

    task automatic pulse(input logic mm, input logic sd, input logic md,
                         input logic clr, input logic [31:0] clrbits);
        @(negedge clk);
        eng_mode_mismatch = mm; eng_slave_done = sd; eng_master_done = md;
        bus_wr = clr; bus_addr = 3'd2; bus_wdata = clrbits;
        @(posedge clk);
        #1 eng_mode_mismatch = 0; eng_slave_done = 0; eng_master_done = 0; bus_wr = 0;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R11 reset state
        rd_reg(3'd1, rd); chk("R11 status", rd, 32'h25);
        rd_reg(3'd3, rd); chk("R11 mask", rd, 32'h1FF);
        chk("R11 irq", {31'h0, irq}, 0);
        chk("R10 dma_tx_req on empty", {31'h0, dma_tx_req}, 1);
        rd_reg(3'd2, rd); chk("R5 tx request set, rx request clear", rd & 32'h9, 32'h1);

        // R1 fill TX to full
        for (int i = 0; i < 8; i++) tx_send(24'hA00 + W'(i), 1'b1);
        rd_reg(3'd1, rd); chk("R1 tx full", (rd >> 1) & 1, 1);
        chk("R10 dma_tx_req low at full", {31'h0, dma_tx_req}, 0);
        // R2 overflow write
        tx_send(24'hBAD, 1'b0);
        rd_reg(3'd2, rd); chk("R2 tx overflow event", (rd >> 1) & 1, 1);
        for (int i = 0; i < 8; i++) tx_take("R1 R2 tx order");
        rd_reg(3'd1, rd); chk("R1 tx empty", (rd >> 5) & 1, 1);
        tx_take("R2 extra");
        rd_reg(3'd2, rd); chk("R2 tx underflow event", (rd >> 2) & 1, 1);

        // R3 RX order
        for (int i = 0; i < 3; i++) rx_send(24'h5500 + W'(i * 7), 1'b1);
        for (int i = 0; i < 3; i++) rx_take("R3 rx order");
        rd_reg(3'd1, rd); chk("R3 rx empty", rd & 1, 1);
        rd_reg(3'd0, rd); chk("R4 empty read value", rd, 0);
        rd_reg(3'd2, rd); chk("R4 rx underflow event", (rd >> 5) & 1, 1);

        // R4 RX overflow
        for (int i = 0; i < 9; i++) rx_send(24'h7700 + W'(i), i < 8);
        rd_reg(3'd2, rd); chk("R4 rx overflow event", (rd >> 4) & 1, 1);
        chk("R5 rx request event", (rd >> 3) & 1, 1);
        rd_reg(3'd1, rd); chk("R3 rx full", (rd >> 4) & 1, 1);
        chk("R10 dma_rx_req", {31'h0, dma_rx_req}, 1);
        wr_reg(3'd5, 32'h1);
        #1 chk("R10 dma off rx", {31'h0, dma_rx_req}, 0);
        chk("R10 dma off tx", {31'h0, dma_tx_req}, 0);
        wr_reg(3'd5, 32'h0);

        // R9 RX flush with TX holding data
        tx_send(24'h111, 1'b1);
        tx_send(24'h222, 1'b1);
        wr_reg(3'd4, 32'h1);
        rx_exp.delete();
        rd_reg(3'd4, rd); chk("R9 rx flush busy", rd, 32'h1);
        rd_reg(3'd1, rd); chk("R9 ready low, rx empty", rd & 32'h5, 32'h1);
        rd_reg(3'd4, rd); chk("R9 flush bit returns 0", rd, 32'h0);
        rd_reg(3'd1, rd); chk("R9 ready back", (rd >> 2) & 1, 1);
        tx_take("R9 tx untouched");
        tx_take("R9 tx untouched");
        // TX flush
        for (int i = 0; i < 3; i++) tx_send(24'h333 + W'(i), 1'b1);
        wr_reg(3'd4, 32'h2);
        tx_exp.delete();
        rd_reg(3'd4, rd); chk("R9 tx flush busy", rd, 32'h2);
        repeat (2) @(posedge clk);
        #1 rd_reg(3'd1, rd); chk("R9 tx empty after flush", rd & 32'h24, 32'h24);

        // R6 sticky + W1C
        pulse(1, 0, 0, 0, 0);
        repeat (2) @(posedge clk);
        rd_reg(3'd2, rd); chk("R6 mode mismatch sticky", (rd >> 6) & 1, 1);
        wr_reg(3'd2, 32'h40);
        rd_reg(3'd2, rd); chk("R6 w1c clears", (rd >> 6) & 1, 0);
        // R7 set wins over clear
        pulse(0, 1, 0, 1, 32'h80);
        rd_reg(3'd2, rd); chk("R7 set wins", (rd >> 7) & 1, 1);

        // R8 mask and irq
        chk("R8 irq masked", {31'h0, irq}, 0);
        wr_reg(3'd3, 32'h0FF);
        #1 chk("R8 irq no master done yet", {31'h0, irq}, 0);
        pulse(0, 0, 1, 0, 0);
        chk("R8 irq on unmasked", {31'h0, irq}, 1);
        rd_reg(3'd1, rd); chk("R8 status summary", (rd >> 3) & 1, 1);
        wr_reg(3'd2, 32'h100);
        #1 chk("R8 irq after clear", {31'h0, irq}, 0);
        rd_reg(3'd1, rd); chk("R8 status summary clear", (rd >> 3) & 1, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule